// File: doc/BRIEF.md
# Host Register Front End for a Serial-Bus Controller

This block sits between an 8-bit asynchronous microprocessor bus and the internals of a serial-bus controller. The host selects one of four direct locations with two address lines and moves bytes with separate chip-select, write and read strobes. The four locations are a status byte, a data byte, a control byte and an indirect access port. The status location is shared: reading it returns engine status, and writing it loads a 3-bit pointer. The pointer picks which of eight configuration slots the indirect port reaches.

The write strobes are brought into the system clock through a synchronizer. A write takes effect once, after the first of the two strobes is released. Reads are combinational from the address lines, so the data bus is valid while the read strobes are held. An active-low open-drain interrupt request is derived from the control byte's interrupt flag, gated by its enable bit. The serial engine is represented only by status, flag-set and receive-load ports.

Top module: `hbus_regfile`

## Requirements
- R1: After `rst_n` is low: data = 0x00, control = 0x00, pointer = 0, slot 0 (byte count) = 0x00, slot 1 (own address) = 0x00, slot 2 (clock low time) = 0x9D, slot 3 (clock high time) = 0x86, slot 4 (timeout) = 0xFF, slot 6 (mode) = 0. `int_pull` and `srst_pulse` are low.
- R2: A write needs `bus_ce_n` and `bus_wr_n` both low. It takes effect exactly once, on the third rising clock edge after the first of the two strobes rises, whichever strobe that is. No register changes while both strobes are held.
- R3: `bus_doe` is high only while `bus_ce_n` and `bus_rd_n` are both low. At all other times the data bus is released.
- R4: A read of address 0 returns `{eng_state[4:0], 3'b000}`.
- R5: A write to address 0 loads the pointer from `bus_din[2:0]` and ignores bits [7:3]. The pointer selects the slot reached through address 2 for both reads and writes.
- R6: Address 1 is a read/write data byte. A pulse on `eng_rx_we` loads `eng_rx_data` into it on the next clock edge.
- R7: Address 3 is the control byte, laid out as bits [7:3] = {enable-acknowledge, interface-enable, start, stop, interrupt flag}. Bits [2:0] always read as zero. The host writes bits [7:4] directly.
- R8: The interrupt flag (bit 3) is set by a pulse on `eng_si_set`. A host write of 0 to bit 3 clears it, and a host write of 1 leaves it unchanged. If a set pulse and a clearing write land on the same edge, the flag ends up set.
- R9: Through address 2, slots 0 to 4 are 8-bit read/write registers. Slot 6 holds 2 bits in [1:0], and its upper bits read as zero.
- R10: A write to slot 5 raises `srst_pulse` for one clock, with the written byte on `srst_data`. Slot 5 reads as 0x00.
- R11: Slot 7 reads as 0x00, and writes to it change nothing.
- R12: `int_pull` is high exactly when both the interrupt flag and interface-enable (bit 6) are set. It follows them on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Host chip select, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_addr | input | 2 | Direct location select |
| bus_din | input | 8 | Byte from host |
| bus_dout | output | 8 | Byte to host |
| bus_doe | output | 1 | Data bus drive enable for the pad |
| eng_state | input | 5 | Engine status code |
| eng_si_set | input | 1 | Engine event, sets interrupt flag |
| eng_rx_we | input | 1 | Engine loads received byte |
| eng_rx_data | input | 8 | Received byte |
| ctrl_q | output | 8 | Control byte image |
| data_q | output | 8 | Data byte |
| cnt_q | output | 8 | Slot 0, byte count |
| own_q | output | 8 | Slot 1, own address |
| scll_q | output | 8 | Slot 2, clock low time |
| sclh_q | output | 8 | Slot 3, clock high time |
| tmo_q | output | 8 | Slot 4, timeout |
| mode_q | output | 2 | Slot 6, mode |
| srst_pulse | output | 1 | One-clock software reset request |
| srst_data | output | 8 | Byte written with the reset request |
| int_pull | output | 1 | Drive the open-drain interrupt pin low |

## Verification
The hardest case to reach is an engine flag-set pulse that arrives on the same clock edge as the commit of a host write clearing the flag. That edge exists only three clocks after a strobe release, inside the synchronizer delay. The bench's write task has a collide option. It raises `eng_si_set` on the falling clock edge just before that commit edge, and the reference model then expects the flag to survive. Release order is also varied, with chip select released first in some writes and the write strobe first in others. Every pointer value, including the write-only and empty slots, is walked with junk in the upper pointer bits.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int DW      = 8;
  localparam int AW      = 2;
  localparam int PW      = 3;
  localparam int NSLOT   = 2 ** PW;
  localparam int NGEN    = 5;
  localparam int MODE_W  = 2;
  localparam int STATE_W = 5;
  localparam int CTL_W   = 5;
  localparam int IX_SRST = 5;
  localparam int IX_MODE = 6;

  // direct locations
  localparam logic [AW-1:0] A_STAT = 2'b00;
  localparam logic [AW-1:0] A_DATA = 2'b01;
  localparam logic [AW-1:0] A_IND  = 2'b10;
  localparam logic [AW-1:0] A_CTRL = 2'b11;

  // control field positions inside ctl register {aa,ensio,sta,sto,si}
  localparam int C_SI    = 0;
  localparam int C_ENSIO = 3;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int            W       = 2,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_n;

  always_comb begin
    st_n[0] = d;
    for (int i = 1; i < STAGES; i++) st_n[i] = st_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= st_n;
  end

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/hbus_wr_capture.sv
module hbus_wr_capture
  import hbus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_s,
  input  logic          wr_s,
  input  logic [AW-1:0] addr_raw,
  input  logic [DW-1:0] din_raw,
  output logic          commit,
  output wr_cmd_t       cmd
);
  logic    active;
  logic    act_q, act_n;
  wr_cmd_t hold_q, hold_n;

  assign active = ~ce_s & ~wr_s;

  always_comb begin
    act_n  = active;
    hold_n = hold_q;
    if (active) hold_n = '{addr: addr_raw, data: din_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      act_q  <= act_n;
      hold_q <= hold_n;
    end
  end

  assign commit = act_q & ~active;
  assign cmd    = hold_q;

  p_commit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/hbus_ind_bank.sv
module hbus_ind_bank
  import hbus_pkg::*;
#(
  parameter logic [NGEN-1:0][DW-1:0] RST_VALS = '0,
  parameter logic [MODE_W-1:0]       MODE_RST = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [PW-1:0]             idx,
  input  logic [DW-1:0]             wdata,
  output logic [DW-1:0]             rdata,
  output logic [NGEN-1:0][DW-1:0]   gen_q,
  output logic [MODE_W-1:0]         mode_q,
  output logic                      srst_pulse,
  output logic [DW-1:0]             srst_data
);
  // plain byte slots
  for (genvar g = 0; g < NGEN; g++) begin : g_slot
    logic          hit;
    logic [DW-1:0] nxt;
    assign hit = wr_en && (idx == PW'(g));
    always_comb nxt = hit ? wdata : gen_q[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gen_q[g] <= RST_VALS[g];
      else        gen_q[g] <= nxt;
    end
  end

  // mode slot and reset strobe slot
  logic              mode_hit, srst_hit;
  logic [MODE_W-1:0] mode_n;
  logic [DW-1:0]     srst_data_n;

  assign mode_hit = wr_en && (idx == PW'(IX_MODE));
  assign srst_hit = wr_en && (idx == PW'(IX_SRST));

  always_comb begin
    mode_n      = mode_hit ? wdata[MODE_W-1:0] : mode_q;
    srst_data_n = srst_hit ? wdata : srst_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_RST;
      srst_pulse <= 1'b0;
      srst_data  <= '0;
    end else begin
      mode_q     <= mode_n;
      srst_pulse <= srst_hit;
      srst_data  <= srst_data_n;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NGEN; i++) if (idx == PW'(i)) rdata = gen_q[i];
    if (idx == PW'(IX_MODE)) rdata = {{(DW-MODE_W){1'b0}}, mode_q};
  end

  p_srst_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_pulse |=> !srst_pulse);
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_hit |=> $stable(mode_q));
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile
  import hbus_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  CNT_RST     = 8'h00,
  parameter logic [7:0]  OWN_RST     = 8'h00,
  parameter logic [7:0]  SCLL_RST    = 8'h9D,
  parameter logic [7:0]  SCLH_RST    = 8'h86,
  parameter logic [7:0]  TMO_RST     = 8'hFF,
  parameter logic [1:0]  MODE_RST    = 2'b00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_ce_n,
  input  logic        bus_wr_n,
  input  logic        bus_rd_n,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_din,
  output logic [7:0]  bus_dout,
  output logic        bus_doe,
  input  logic [4:0]  eng_state,
  input  logic        eng_si_set,
  input  logic        eng_rx_we,
  input  logic [7:0]  eng_rx_data,
  output logic [7:0]  ctrl_q,
  output logic [7:0]  data_q,
  output logic [7:0]  cnt_q,
  output logic [7:0]  own_q,
  output logic [7:0]  scll_q,
  output logic [7:0]  sclh_q,
  output logic [7:0]  tmo_q,
  output logic [1:0]  mode_q,
  output logic        srst_pulse,
  output logic [7:0]  srst_data,
  output logic        int_pull
);
  localparam logic [NGEN-1:0][DW-1:0] GEN_RST = {TMO_RST, SCLH_RST, SCLL_RST, OWN_RST, CNT_RST};
  localparam int PAD_W = DW - CTL_W;

  // strobe synchronizer: bit1 = chip select, bit0 = write
  logic [1:0] strb_s;
  hbus_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk), .rst_n (rst_n), .d ({bus_ce_n, bus_wr_n}), .q (strb_s)
  );

  logic    commit;
  wr_cmd_t cmd;
  hbus_wr_capture u_cap (
    .clk (clk), .rst_n (rst_n), .ce_s (strb_s[1]), .wr_s (strb_s[0]),
    .addr_raw (bus_addr), .din_raw (bus_din), .commit (commit), .cmd (cmd)
  );

  logic wr_ptr, wr_dat, wr_ind, wr_ctl;
  assign wr_ptr = commit && (cmd.addr == A_STAT);
  assign wr_dat = commit && (cmd.addr == A_DATA);
  assign wr_ind = commit && (cmd.addr == A_IND);
  assign wr_ctl = commit && (cmd.addr == A_CTRL);

  // direct registers
  logic [PW-1:0]    ptr_q, ptr_n;
  logic [DW-1:0]    dat_q, dat_n;
  logic [CTL_W-1:0] ctl_q, ctl_n;
  logic             int_q, int_n;

  always_comb begin
    ptr_n = wr_ptr ? cmd.data[PW-1:0] : ptr_q;
    dat_n = dat_q;
    if (eng_rx_we) dat_n = eng_rx_data;
    if (wr_dat)    dat_n = cmd.data;
    ctl_n = ctl_q;
    if (wr_ctl) begin
      ctl_n[CTL_W-1:1] = cmd.data[DW-1:PAD_W+1];
      if (!cmd.data[PAD_W]) ctl_n[C_SI] = 1'b0;
    end
    if (eng_si_set) ctl_n[C_SI] = 1'b1;
    int_n = ctl_n[C_SI] & ctl_n[C_ENSIO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      dat_q <= '0;
      ctl_q <= '0;
      int_q <= 1'b0;
    end else begin
      ptr_q <= ptr_n;
      dat_q <= dat_n;
      ctl_q <= ctl_n;
      int_q <= int_n;
    end
  end

  // indirect bank
  logic [DW-1:0]           ind_rdata;
  logic [NGEN-1:0][DW-1:0] gen_q;
  hbus_ind_bank #(.RST_VALS(GEN_RST), .MODE_RST(MODE_RST)) u_bank (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_ind), .idx (ptr_q), .wdata (cmd.data),
    .rdata (ind_rdata), .gen_q (gen_q), .mode_q (mode_q),
    .srst_pulse (srst_pulse), .srst_data (srst_data)
  );

  // read path, combinational from the raw bus
  always_comb begin
    unique case (bus_addr)
      A_STAT:  bus_dout = {eng_state, {(DW-STATE_W){1'b0}}};
      A_DATA:  bus_dout = dat_q;
      A_IND:   bus_dout = ind_rdata;
      default: bus_dout = {ctl_q, {PAD_W{1'b0}}};
    endcase
  end
  assign bus_doe = ~bus_ce_n & ~bus_rd_n;

  assign ctrl_q   = {ctl_q, {PAD_W{1'b0}}};
  assign data_q   = dat_q;
  assign cnt_q    = gen_q[0];
  assign own_q    = gen_q[1];
  assign scll_q   = gen_q[2];
  assign sclh_q   = gen_q[3];
  assign tmo_q    = gen_q[4];
  assign int_pull = int_q;

  p_si_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_si_set |=> ctl_q[C_SI]);
  p_int_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    int_pull |-> (ctl_q[C_SI] && ctl_q[C_ENSIO]));
  p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ptr |=> $stable(ptr_q));
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_dat && !eng_rx_we) |=> $stable(dat_q));
endmodule

// File: tb/hbus_regfile_test.sv
`timescale 1ns/1ps
module hbus_regfile_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic       bus_ce_n, bus_wr_n, bus_rd_n;
  logic [1:0] bus_addr;
  logic [7:0] bus_din, bus_dout;
  logic       bus_doe;
  logic [4:0] eng_state;
  logic       eng_si_set, eng_rx_we;
  logic [7:0] eng_rx_data;
  logic [7:0] ctrl_q, data_q, cnt_q, own_q, scll_q, sclh_q, tmo_q, srst_data;
  logic [1:0] mode_q;
  logic       srst_pulse, int_pull;

  hbus_regfile uut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
    .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .eng_state(eng_state), .eng_si_set(eng_si_set), .eng_rx_we(eng_rx_we),
    .eng_rx_data(eng_rx_data), .ctrl_q(ctrl_q), .data_q(data_q), .cnt_q(cnt_q),
    .own_q(own_q), .scll_q(scll_q), .sclh_q(sclh_q), .tmo_q(tmo_q), .mode_q(mode_q),
    .srst_pulse(srst_pulse), .srst_data(srst_data), .int_pull(int_pull)
  );

  int compared = 0;
  int mismatched = 0;

  // behavioural model
  int m_ptr, m_data, m_ctl, m_si, m_int;
  int m_slot [8];
  int m_srst, m_srst_d;
  bit cmp_on = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ptr = 0; m_data = 0; m_ctl = 0; m_si = 0; m_int = 0; m_srst = 0; m_srst_d = 0;
    foreach (m_slot[i]) m_slot[i] = 0;
    m_slot[2] = 'h9D; m_slot[3] = 'h86; m_slot[4] = 'hFF;
  endtask

  function automatic int ctl_img();
    return (m_ctl & 'hF0) | (m_si << 3);
  endfunction

  function automatic int exp_read(input int a);
    case (a)
      0: return int'(eng_state) << 3;
      1: return m_data;
      2: return m_slot[m_ptr];
      default: return ctl_img();
    endcase
  endfunction

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      chk("R7",  "ctrl",  int'(ctrl_q),  ctl_img());
      chk("R6",  "data",  int'(data_q),  m_data);
      chk("R9",  "cnt",   int'(cnt_q),   m_slot[0]);
      chk("R9",  "own",   int'(own_q),   m_slot[1]);
      chk("R9",  "scll",  int'(scll_q),  m_slot[2]);
      chk("R9",  "sclh",  int'(sclh_q),  m_slot[3]);
      chk("R9",  "tmo",   int'(tmo_q),   m_slot[4]);
      chk("R9",  "mode",  int'(mode_q),  m_slot[6]);
      chk("R10", "srst",  int'(srst_pulse), m_srst);
      if (m_srst) chk("R10", "srst_data", int'(srst_data), m_srst_d);
      chk("R12", "int",   int'(int_pull), m_int);
    end
  end

  task automatic apply_write(input int a, input int d);
    case (a)
      0: m_ptr = d & 7;
      1: m_data = d;
      2: begin
        if (m_ptr < 5) m_slot[m_ptr] = d;
        else if (m_ptr == 6) m_slot[6] = d & 3;
        else if (m_ptr == 5) begin m_srst = 1; m_srst_d = d; end
      end
      default: begin
        m_ctl = d & 'hF0;
        if (((d >> 3) & 1) == 0) m_si = 0;
      end
    endcase
  endtask

  // R2: commit lands on the third rising edge after the first strobe release
  task automatic do_write(input int a, input int d, input bit ce_first, input bit collide);
    @(negedge clk);
    bus_addr = 2'(a); bus_din = 8'(d); bus_ce_n = 0; bus_wr_n = 0;
    repeat (3) @(negedge clk);
    if (ce_first) bus_ce_n = 1; else bus_wr_n = 1;
    @(posedge clk);
    @(negedge clk);
    bus_ce_n = 1; bus_wr_n = 1;
    @(posedge clk);
    @(negedge clk);
    if (collide) eng_si_set = 1;
    @(posedge clk);
    #1;
    apply_write(a, d);
    if (collide) m_si = 1;
    m_int = m_si & ((m_ctl >> 6) & 1);
    @(negedge clk);
    eng_si_set = 0;
    @(posedge clk);
    #1;
    m_srst = 0;
  endtask

  task automatic si_event();
    @(negedge clk);
    eng_si_set = 1;
    @(posedge clk);
    #1;
    m_si = 1;
    m_int = (m_ctl >> 6) & 1;
    @(negedge clk);
    eng_si_set = 0;
  endtask

  task automatic rx_load(input int d);
    @(negedge clk);
    eng_rx_we = 1; eng_rx_data = 8'(d);
    @(posedge clk);
    #1;
    m_data = d;
    @(negedge clk);
    eng_rx_we = 0;
  endtask

  task automatic do_read(input string req, input int a);
    @(negedge clk);
    bus_addr = 2'(a); bus_ce_n = 0; bus_rd_n = 0;
    #1;
    chk("R3", "doe during read", int'(bus_doe), 1);
    chk(req, $sformatf("read addr %0d", a), int'(bus_dout), exp_read(a));
    @(negedge clk);
    bus_ce_n = 1; bus_rd_n = 1;
    #1;
    chk("R3", "doe idle", int'(bus_doe), 0);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 0; bus_ce_n = 1; bus_wr_n = 1; bus_rd_n = 1; bus_addr = 0; bus_din = 0;
    eng_state = 5'b10110; eng_si_set = 0; eng_rx_we = 0; eng_rx_data = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    cmp_on = 1;

    // R1 reset values, R4 status image
    do_read("R4", 0);
    do_read("R1", 1);
    do_read("R1", 3);
    for (int i = 0; i < 8; i++) begin
      do_write(0, i, 0, 0);
      do_read("R1", 2);
    end

    // R3 strobe gating
    @(negedge clk);
    bus_ce_n = 1; bus_rd_n = 0;
    #1 chk("R3", "rd without ce", int'(bus_doe), 0);
    bus_rd_n = 1; bus_ce_n = 0;
    #1 chk("R3", "ce without rd", int'(bus_doe), 0);
    bus_ce_n = 1;

    // R6 and R2 data byte, both release orders
    do_write(1, 'h5A, 0, 0);
    do_read("R6", 1);
    do_write(1, 'hC3, 1, 0);
    do_read("R2", 1);
    rx_load('h77);
    do_read("R6", 1);

    // R7 / R8 control and flag
    do_write(3, 'hF7, 0, 0);
    do_read("R7", 3);
    si_event();
    do_read("R8", 3);
    chk("R12", "int after set", int'(int_pull), 1);
    do_write(3, 'hC8, 1, 0);
    do_read("R8", 3);
    do_write(3, 'hC0, 0, 0);
    do_read("R8", 3);
    chk("R12", "int after clear", int'(int_pull), 0);
    si_event();
    do_write(3, 'hC0, 0, 1);
    do_read("R8", 3);
    chk("R8", "set wins collision", int'(ctrl_q[3]), 1);
    do_write(3, 'h88, 0, 0);
    chk("R12", "int masked by enable", int'(int_pull), 0);
    do_write(3, 'h00, 1, 0);

    // R5, R9, R10, R11 walk every slot with junk in upper pointer bits
    eng_state = 5'b01001;
    for (int i = 0; i < 8; i++) begin
      do_write(0, 'hF8 | i, i[0], 0);
      do_read("R4", 0);
      do_write(2, 'h31 + i * 'h11, 0, 0);
      do_read(i == 5 ? "R10" : (i == 7 ? "R11" : "R9"), 2);
      do_read("R5", 1);
    end

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule